// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the time-varying fractional offset that a fractional-N feedback divider adds to its nominal ratio, so that the synthesized clock sweeps in frequency. It runs from the system clock and advances only in cycles where the phase-detector-rate enable `pfd_en` is high. The shape of the sweep is not fixed. Software supplies twelve 4-bit step sizes. The block adds the first `U` of them upward, retraces them downward in reverse order, and then repeats both passes with the sign inverted. The result is a wave that is symmetric about a programmable 6-bit offset. An offset of zero gives center spread. A nonzero offset shifts the wave so that it acts as down spread.

Each sample is held for a programmable dwell. A new output word appears only at a dwell boundary, and a one-cycle `mod_valid` pulse marks it. The output is a sample stream with no back-pressure: the divider must take every word in the cycle that `mod_valid` is high, and the word then stays unchanged until the next pulse. Two options change the value written: doubling of the wave amplitude, and dithering of the least-significant bit from a free-running pseudo-random sequence. A status pin reports when the configured steps would exceed the headroom above the offset.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst` or `run_en` is low, the accumulated wave, the sample position and the dwell count are cleared. `mod_word` equals `cfg_offset` zero-extended, and `mod_valid` is low. Once running again, the first step adds step 0 in the rising quarter.
- R2: The number of steps used per quarter is U = 2×`cfg_pairs`, clamped to the range 2..12. Step k is `cfg_deltas[4k+3:4k]`.
- R3: Each sample lasts D = `cfg_dwell`+2 enabled cycles. The step is taken on the D-th enabled cycle. The new word appears one clock later with a single-cycle `mod_valid` pulse, and `mod_word` does not change between pulses.
- R4: Let W be the wave value. In quarter 0, step k adds delta k to W. In quarter 1, step k subtracts delta U-1-k. In quarter 2, step k subtracts delta k. In quarter 3, step k adds delta U-1-k. The quarters then repeat from 0.
- R5: One full period is 4·U·D enabled cycles and produces 4·U pulses. The last word of each period equals the offset, because W has returned to 0.
- R6: Without doubling or dither, `mod_word` = (W + `cfg_offset`) mod 256, read as two's complement.
- R7: With `cfg_double` high, `mod_word` = (2·W + `cfg_offset`) mod 256.
- R8: With `cfg_dither` high, bit 0 of the word is XORed with bit 0 of a 16-bit LFSR. The LFSR is seeded to 0xACE1 by `rst` and advances on every `pfd_en` cycle, whether or not `run_en` is high. Each advance shifts the LFSR right and feeds bit0^bit2^bit3^bit5 into bit 15. The bit used is the value before that cycle's shift.
- R9: `cfg_err` is high exactly when the sum of the U used steps exceeds 63 − `cfg_offset`. Steps beyond U do not count.
- R10: Cycles with `pfd_en` low change nothing. No pulse occurs and the dwell count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pfd_en | input | 1 | Phase-detector-rate enable |
| run_en | input | 1 | Modulation enable; low holds the output at the offset |
| cfg_deltas | input | 48 | Twelve 4-bit step sizes, step k in bits 4k+3:4k |
| cfg_pairs | input | 3 | Step pairs per quarter (U = 2×value, clamped 2..12) |
| cfg_dwell | input | 4 | Dwell per sample minus two, in enabled cycles |
| cfg_offset | input | 6 | Offset added to the wave (0 gives center spread) |
| cfg_double | input | 1 | Doubles the wave amplitude |
| cfg_dither | input | 1 | Dithers output bit 0 |
| mod_word | output | 8 | Signed modulation word |
| mod_valid | output | 1 | One-cycle pulse on each new word |
| cfg_err | output | 1 | Step sum exceeds the headroom above the offset |

## Verification
The wave is tried with uniform unit steps, which give a plain triangle and make a wrong period length or a wrong turn-around point obvious. It is also tried with unequal steps, where reversing the wrong quarter, or indexing from the wrong end, changes the values produced. Both run with `pfd_en` high every cycle and with `pfd_en` high one cycle in three, which separates counting of clocks from counting of enabled cycles. Separate runs with doubling and with dither set show that scaling comes before the offset and that only bit 0 flips. Sum-limit cases at, just over, and with large unused steps show where the error flag switches and which steps it counts.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Quarter of the modulation period; order is behavioural.
  typedef enum logic [1:0] {
    Q_RISE    = 2'd0,
    Q_FALL    = 2'd1,
    Q_SINK    = 2'd2,
    Q_RECOVER = 2'd3
  } quarter_t;

  localparam int unsigned LFSR_BITS = 16;
  localparam logic [LFSR_BITS-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_BITS-1:0] LFSR_TAPS = 16'h002D;
endpackage

// File: rtl/ssc_delta_sum.sv
module ssc_delta_sum #(
  parameter int unsigned N_STEPS = 12,
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned UW      = 4,
  parameter int unsigned OFS_W   = 6,
  localparam int unsigned SUM_W  = STEP_W + $clog2(N_STEPS + 1)
) (
  input  logic [N_STEPS*STEP_W-1:0] deltas,
  input  logic [UW-1:0]             used,
  input  logic [OFS_W-1:0]          offset,
  output logic [SUM_W-1:0]          total,
  output logic                      over
);
  localparam int unsigned CMP_W = (SUM_W > OFS_W ? SUM_W : OFS_W) + 1;
  localparam logic [OFS_W-1:0] OFS_MAX = {OFS_W{1'b1}};

  logic [SUM_W-1:0] part [N_STEPS+1];
  assign part[0] = '0;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_acc
    logic [SUM_W-1:0] term;
    assign term = (UW'(i) < used) ?
                  {{(SUM_W-STEP_W){1'b0}}, deltas[i*STEP_W +: STEP_W]} : '0;
    assign part[i+1] = part[i] + term;
  end

  logic [CMP_W-1:0] headroom;
  assign headroom = CMP_W'(OFS_MAX) - CMP_W'(offset);
  assign total    = part[N_STEPS];
  assign over     = CMP_W'(total) > headroom;
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
  import ssc_pkg::*;
#(
  parameter int unsigned UW      = 4,
  parameter int unsigned DWELL_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           pfd_en,
  input  logic [UW-1:0]  used,
  input  logic [DWELL_W-1:0] dwell_sel,
  output logic           step,
  output logic [UW-1:0]  sel_idx,
  output logic           add_dir
);
  localparam int unsigned DCW = DWELL_W + 1;

  logic [DCW-1:0] dwell_q;
  logic [UW-1:0]  idx_q;
  quarter_t       qtr_q;

  logic [DCW-1:0] dwell_last;
  logic [UW-1:0]  idx_last;
  logic           qtr_odd;

  assign dwell_last = DCW'(dwell_sel) + DCW'(1);
  assign idx_last   = used - UW'(1);
  assign qtr_odd    = qtr_q[0];

  assign step    = run_en && pfd_en && (dwell_q >= dwell_last);
  assign sel_idx = qtr_odd ? (idx_last - idx_q) : idx_q;
  assign add_dir = (qtr_q == Q_RISE) || (qtr_q == Q_RECOVER);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      dwell_q <= '0;
      idx_q   <= '0;
      qtr_q   <= Q_RISE;
    end else if (pfd_en) begin
      if (step) begin
        dwell_q <= '0;
        if (idx_q >= idx_last) begin
          idx_q <= '0;
          qtr_q <= quarter_t'(qtr_q + 2'd1);
        end else begin
          idx_q <= idx_q + UW'(1);
        end
      end else begin
        dwell_q <= dwell_q + DCW'(1);
      end
    end
  end
endmodule

// File: rtl/ssc_dither_lfsr.sv
module ssc_dither_lfsr
  import ssc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bit_out
);
  logic [LFSR_BITS-1:0] state_q;
  logic                 fb;

  assign fb      = ^(state_q & LFSR_TAPS);
  assign bit_out = state_q[0];

  always_ff @(posedge clk) begin
    if (rst)      state_q <= LFSR_SEED;
    else if (adv) state_q <= {fb, state_q[LFSR_BITS-1:1]};
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int unsigned N_STEPS = 12,
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned DWELL_W = 4,
  parameter int unsigned OFS_W   = 6,
  parameter int unsigned OUT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pfd_en,
  input  logic                      run_en,
  input  logic [N_STEPS*STEP_W-1:0] cfg_deltas,
  input  logic [CNT_W-1:0]          cfg_pairs,
  input  logic [DWELL_W-1:0]        cfg_dwell,
  input  logic [OFS_W-1:0]          cfg_offset,
  input  logic                      cfg_double,
  input  logic                      cfg_dither,
  output logic [OUT_W-1:0]          mod_word,
  output logic                      mod_valid,
  output logic                      cfg_err
);
  localparam int unsigned UW    = $clog2(N_STEPS + 1);
  localparam int unsigned RAWW  = (CNT_W + 1 > UW) ? CNT_W + 1 : UW;
  localparam int unsigned SUM_W = STEP_W + $clog2(N_STEPS + 1);
  localparam int unsigned ACC_W = SUM_W + 2;
  localparam int unsigned SCL_W = ACC_W + 1;

  // Used step count: twice the pair field, clamped to 2..N_STEPS.
  logic [RAWW-1:0] raw_used;
  logic [UW-1:0]   used;
  assign raw_used = RAWW'({cfg_pairs, 1'b0});
  always_comb begin
    if (raw_used < RAWW'(2))            used = UW'(2);
    else if (raw_used > RAWW'(N_STEPS)) used = UW'(N_STEPS);
    else                                used = UW'(raw_used);
  end

  logic [SUM_W-1:0] step_total;
  ssc_delta_sum #(
    .N_STEPS(N_STEPS), .STEP_W(STEP_W), .UW(UW), .OFS_W(OFS_W)
  ) u_sum (
    .deltas(cfg_deltas), .used(used), .offset(cfg_offset),
    .total(step_total), .over(cfg_err)
  );

  logic          step;
  logic [UW-1:0] sel_idx;
  logic          add_dir;
  ssc_sequencer #(.UW(UW), .DWELL_W(DWELL_W)) u_seq (
    .clk(clk), .rst(rst), .run_en(run_en), .pfd_en(pfd_en),
    .used(used), .dwell_sel(cfg_dwell),
    .step(step), .sel_idx(sel_idx), .add_dir(add_dir)
  );

  logic dbit;
  ssc_dither_lfsr u_lfsr (.clk(clk), .rst(rst), .adv(pfd_en), .bit_out(dbit));

  // Wave accumulator (two's complement).
  logic [STEP_W-1:0] sel_delta;
  logic [ACC_W-1:0]  acc_q, acc_step, delta_ext;
  assign sel_delta = cfg_deltas[sel_idx*STEP_W +: STEP_W];
  assign delta_ext = {{(ACC_W-STEP_W){1'b0}}, sel_delta};
  assign acc_step  = add_dir ? (acc_q + delta_ext) : (acc_q - delta_ext);

  logic [SCL_W-1:0] scaled, biased;
  logic [OUT_W-1:0] next_word, idle_word;
  assign scaled    = cfg_double ? {acc_step, 1'b0} : {acc_step[ACC_W-1], acc_step};
  assign biased    = scaled + {{(SCL_W-OFS_W){1'b0}}, cfg_offset};
  assign next_word = biased[OUT_W-1:0] ^ {{(OUT_W-1){1'b0}}, dbit & cfg_dither};
  assign idle_word = {{(OUT_W-OFS_W){1'b0}}, cfg_offset};

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      acc_q     <= '0;
      mod_word  <= idle_word;
      mod_valid <= 1'b0;
    end else begin
      mod_valid <= step;
      if (step) begin
        acc_q    <= acc_step;
        mod_word <= next_word;
      end
    end
  end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int unsigned OFS_W = 6,
  parameter int unsigned OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pfd_en,
  input logic             run_en,
  input logic [OFS_W-1:0] cfg_offset,
  input logic             cfg_double,
  input logic             cfg_dither,
  input logic             cfg_err,
  input logic [OUT_W-1:0] mod_word,
  input logic             mod_valid
);
  // R1: idle or reset in the previous cycle leaves the offset on the output.
  a_r1_idle_offset: assert property (@(posedge clk) disable iff (rst)
    (!$past(run_en) || $past(rst)) |->
      (mod_word == {{(OUT_W-OFS_W){1'b0}}, $past(cfg_offset)}) && !mod_valid);

  // R3: a pulse never lasts more than one cycle (dwell is at least two).
  a_r3_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
    mod_valid |=> !mod_valid);

  // R3: without a pulse, a running output holds its value.
  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!mod_valid && $past(run_en) && !$past(rst)) |-> $stable(mod_word));

  // R10: a pulse needs an enabled, running cycle before it.
  a_r10_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
    mod_valid |-> ($past(pfd_en) && $past(run_en)));

  // R9: a legal, unscaled, undithered profile stays within +/-63.
  a_r9_legal_range: assert property (@(posedge clk) disable iff (rst)
    (mod_valid && !$past(cfg_err) && !$past(cfg_double) && !$past(cfg_dither)) |->
      (($signed(mod_word) <= 63) && ($signed(mod_word) >= -63)));
endmodule

bind ssc_profile_gen ssc_profile_chk #(.OFS_W(OFS_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .pfd_en(pfd_en), .run_en(run_en),
  .cfg_offset(cfg_offset), .cfg_double(cfg_double), .cfg_dither(cfg_dither),
  .cfg_err(cfg_err), .mod_word(mod_word), .mod_valid(mod_valid)
);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, pfd_en = 1'b0, run_en = 1'b0;
  logic [47:0] cfg_deltas = '0;
  logic [2:0]  cfg_pairs = '0;
  logic [3:0]  cfg_dwell = '0;
  logic [5:0]  cfg_offset = '0;
  logic        cfg_double = 1'b0, cfg_dither = 1'b0;
  logic [7:0]  mod_word;
  logic        mod_valid, cfg_err;

  ssc_profile_gen u0 (.*);

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  int    pfd_mode = 0;  // 0 every cycle, 1 one in three, 2 never
  int    pfd_ctr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    pfd_ctr = (pfd_ctr + 1) % 3;
    pfd_en <= (pfd_mode == 0) ? 1'b1 : (pfd_mode == 1) ? (pfd_ctr == 0) : 1'b0;
  end

  // Behavioural reference model, evaluated at every rising edge.
  int m_q, m_k, m_dw, m_acc, m_lfsr, m_word, m_valid;

  function automatic int used_n();
    int u = 2 * cfg_pairs;
    if (u < 2) u = 2;
    if (u > 12) u = 12;
    return u;
  endfunction

  function automatic int delta_at(input int k);
    return (cfg_deltas >> (4 * k)) & 15;
  endfunction

  function automatic bit exp_err();
    int s = 0;
    for (int i = 0; i < used_n(); i++) s += delta_at(i);
    return s > (63 - cfg_offset);
  endfunction

  always @(posedge clk) begin
    int u, d, dbit, idx;
    if (rst) begin
      m_lfsr = 16'hACE1; m_q = 0; m_k = 0; m_dw = 0; m_acc = 0;
      m_word = cfg_offset; m_valid = 0;
    end else begin
      m_valid = 0;
      dbit = m_lfsr & 1;
      if (pfd_en)
        m_lfsr = (m_lfsr >> 1) |
                 (((m_lfsr ^ (m_lfsr >> 2) ^ (m_lfsr >> 3) ^ (m_lfsr >> 5)) & 1) << 15);
      u = used_n();
      d = cfg_dwell + 2;
      if (!run_en) begin
        m_q = 0; m_k = 0; m_dw = 0; m_acc = 0; m_word = cfg_offset;
      end else if (pfd_en) begin
        if (m_dw == d - 1) begin
          m_dw = 0;
          idx = (m_q % 2 == 1) ? (u - 1 - m_k) : m_k;
          if (m_q == 0 || m_q == 3) m_acc += delta_at(idx);
          else m_acc -= delta_at(idx);
          m_word = ((cfg_double ? 2 * m_acc : m_acc) + cfg_offset) & 255;
          if (cfg_dither) m_word ^= dbit;
          m_valid = 1;
          if (m_k == u - 1) begin m_k = 0; m_q = (m_q + 1) % 4; end
          else m_k++;
        end else m_dw++;
      end
    end
    #1;
    check(mod_valid == m_valid[0], {cur_req, " strobe"}, mod_valid, m_valid);
    check(mod_word == m_word[7:0], {cur_req, " word"}, mod_word, m_word);
    check(cfg_err == exp_err(), {cur_req, " err"}, cfg_err, exp_err());
  end

  task automatic configure(input logic [47:0] dl, input int pairs, input int dw,
                           input int ofs, input bit dbl, input bit dth);
    @(negedge clk);
    run_en = 1'b0;
    cfg_deltas = dl; cfg_pairs = pairs[2:0]; cfg_dwell = dw[3:0];
    cfg_offset = ofs[5:0]; cfg_double = dbl; cfg_dither = dth;
    @(negedge clk);
  endtask

  // Counts pulses over n rising edges after run_en goes high.
  task automatic run_count(input int n, output int pulses);
    pulses = 0;
    run_en = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (mod_valid) pulses++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int p;
    cfg_offset = 6'd17;
    repeat (3) @(negedge clk);
    check(mod_word == 8'd17 && !mod_valid, "R1 reset state", mod_word, 17);
    rst = 1'b0;

    // R5/R4: unit-step triangle, U=6, D=2, center spread.
    cur_req = "R5";
    configure(48'h111111111111, 3, 0, 0, 0, 0);
    run_count(48, p);
    check(p == 24, "R5 pulses per period", p, 24);
    check(mod_word == 8'd0, "R5 end of period at offset", mod_word, 0);

    // R2: pair field 0 clamps to two steps; D=3.
    cur_req = "R2";
    configure(48'h000000000021, 0, 1, 5, 0, 0);
    run_count(24, p);
    check(p == 8, "R2 clamp low pulses", p, 8);
    check(mod_word == 8'd5, "R2 clamp low end value", mod_word, 5);
    // R2: pair field 7 clamps to twelve steps; D=2.
    configure(48'h111111111111, 7, 0, 0, 0, 0);
    run_count(96, p);
    check(p == 48, "R2 clamp high pulses", p, 48);

    // R4/R6/R10: shaped steps, sparse enable, down-spread offset.
    cur_req = "R4";
    configure(48'h123432101234, 6, 3, 20, 0, 0);
    pfd_mode = 1;
    run_count(200, p);
    pfd_mode = 0;
    cur_req = "R6";
    configure(48'h000000003521, 2, 2, 30, 0, 0);
    run_count(120, p);

    // R10: no enabled cycles, no pulses, word held.
    cur_req = "R10";
    begin
      logic [7:0] held;
      held = mod_word;
      pfd_mode = 2;
      repeat (30) begin
        @(negedge clk);
        check(!mod_valid && mod_word == held, "R10 idle enable", mod_word, held);
      end
      pfd_mode = 0;
    end

    // R1: disable mid-run, then restart from the first step.
    cur_req = "R1";
    @(negedge clk); run_en = 1'b0;
    @(negedge clk);
    check(mod_word == 8'd30 && !mod_valid, "R1 disabled holds offset", mod_word, 30);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    check(mod_valid && mod_word == 8'd31, "R1 restart first step", mod_word, 31);

    // R7: doubling before the offset.
    cur_req = "R7";
    configure(48'h000000002413, 2, 0, 10, 1, 0);
    run_count(40, p);

    // R8: dither on the least-significant bit, sparse enable.
    cur_req = "R8";
    configure(48'h000000002222, 2, 1, 40, 0, 1);
    pfd_mode = 1;
    run_count(150, p);
    pfd_mode = 0;

    // R9: sum limit.
    cur_req = "R9";
    configure(48'h555555555555, 6, 0, 3, 0, 0);
    check(cfg_err == 1'b0, "R9 sum equals limit", cfg_err, 0);
    configure(48'h555555555555, 6, 0, 4, 0, 0);
    check(cfg_err == 1'b1, "R9 sum over limit", cfg_err, 1);
    configure(48'hFFFFFFFF5555, 2, 0, 43, 0, 0);
    check(cfg_err == 1'b0, "R9 unused steps ignored", cfg_err, 0);
    configure(48'hFFFFFFFF5555, 2, 0, 44, 0, 0);
    check(cfg_err == 1'b1, "R9 used sum over limit", cfg_err, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule